// File: doc/BRIEF.md
# Translation Lookaside Cache with Explicit Invalidation

This block is a small, fully associative cache of recent leaf translations. It sits between a lookup client and a page table walker. A request carries a 32-bit virtual address, a write flag and a user flag. One cycle later the block answers with one of three results:

- a hit, carrying the physical address;
- a protection fault, when the cached permissions forbid the access;
- a miss, which tells the walker to fetch the translation.

The walker answers a miss through a refill port. A successful refill is written into the cache. A failed walk is never stored.

The cache never watches page table memory, so an entry stays in place after the table in memory changes. Software removes entries in one of two ways. It can invalidate the single page that matches a given virtual page number. It can also pulse the base-register-write input, which clears every entry. Each entry covers one 4 KiB page. The tag is the upper 20 address bits. The data is the frame number plus a write-permit bit and a user-permit bit.

Top module: `xlate_cache`

## Requirements
- R1: Each cycle with `lk_valid` high produces exactly one result in the next cycle: `rsp_valid` high together with exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault`. The request's address, write flag and user flag are echoed on `rsp_vaddr`, `rsp_write` and `rsp_user`. In a cycle after no request, `rsp_valid` is low.
- R2: On a hit that the permissions allow, `rsp_paddr` is the cached 20-bit frame number in bits 31..12, followed by the request's address bits 11..0.
- R3: On a miss, `rsp_miss` is high, which is the request to the walker, and `rsp_paddr` is zero.
- R4: A refill with `fill_err` low stores its page, so that any later lookup within that page hits. A refill for a page that is already cached overwrites that entry in place instead of adding a second one.
- R5: A refill with `fill_err` high changes no entry, so a later lookup of that page misses.
- R6: A cached hit raises `rsp_fault` when the access is forbidden: a write to an entry with its write-permit bit clear, or a user access to an entry with its user-permit bit clear. In that case `rsp_paddr` is zero and the entry is kept.
- R7: A cached translation keeps returning its stored frame until that entry is invalidated, flushed or overwritten. No other event changes it.
- R8: An invalidate with `inv_valid` high removes only the entry whose page number equals `inv_vpn`. Other entries keep hitting.
- R9: A pulse on `base_wr` empties the cache and returns the replacement pointer to slot 0.
- R10: When an invalidate or a flush arrives in the same cycle as a refill, it is applied after the refill. A refilled page that matches the invalidated page, or any refill that coincides with a flush, is therefore absent afterwards.
- R11: A new page goes into the lowest-numbered empty slot. When no slot is empty, it goes into the slot named by a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, only on such an eviction.
- R12: After reset every entry is empty and every response output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_write | input | 1 | Lookup is a write |
| lk_user | input | 1 | Lookup is from user mode |
| rsp_valid | output | 1 | Result present (one cycle after request) |
| rsp_hit | output | 1 | Permitted hit |
| rsp_miss | output | 1 | Miss; request to walker |
| rsp_fault | output | 1 | Protection fault on a cached entry |
| rsp_paddr | output | 32 | Physical address on a hit, else zero |
| rsp_vaddr | output | 32 | Echo of the request address |
| rsp_write | output | 1 | Echo of the write flag |
| rsp_user | output | 1 | Echo of the user flag |
| fill_valid | input | 1 | Walker result present |
| fill_vpn | input | 20 | Virtual page number of the walk |
| fill_err | input | 1 | Walk failed; result not stored |
| fill_pfn | input | 20 | Physical frame number |
| fill_wr_ok | input | 1 | Page permits writes |
| fill_usr_ok | input | 1 | Page permits user access |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Page number to invalidate |
| base_wr | input | 1 | Directory base register written; flush all |

## Verification
The bench builds the block with its default values: 8 entries, 32-bit virtual and physical addresses and 4 KiB pages. With only eight slots, a short sequence can fill every slot, force two evictions and then reopen a slot with an invalidate. That brings the first-empty-slot choice and the wrapping round-robin pointer within reach. The 12-bit offset makes the address split easy to predict by hand for hit addresses.

// File: rtl/xlc_pkg.sv
package xlc_pkg;

  typedef enum logic [1:0] {
    RK_MISS  = 2'd0,
    RK_HIT   = 2'd1,
    RK_FAULT = 2'd2
  } rsp_kind_e;

  // An access is refused when it writes a page without write permission,
  // or comes from user mode on a page without user permission.
  function automatic logic perm_denied(input logic is_wr, input logic is_usr,
                                       input logic wr_ok, input logic usr_ok);
    return (is_wr && !wr_ok) || (is_usr && !usr_ok);
  endfunction

endpackage

// File: rtl/xlc_entry_array.sv
module xlc_entry_array #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ENTRIES-1:0] fill_we,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]   fill_pfn,
  input  logic               fill_wr_ok,
  input  logic               fill_usr_ok,
  input  logic               inv_valid,
  input  logic [VPN_W-1:0]   inv_vpn,
  input  logic               flush,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] fill_match_vec,
  output logic [PFN_W-1:0]   hit_pfn,
  output logic               hit_wr_ok,
  output logic               hit_usr_ok
);

  logic [VPN_W-1:0] tag_q   [ENTRIES];
  logic [PFN_W-1:0] pfn_q   [ENTRIES];
  logic [ENTRIES-1:0] wrok_q;
  logic [ENTRIES-1:0] usrok_q;
  logic [ENTRIES-1:0] valid_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [VPN_W-1:0] tag_n;
    logic             valid_n;

    // Refill first, then invalidate/flush on the refilled state.
    always_comb begin
      tag_n   = fill_we[i] ? fill_vpn : tag_q[i];
      valid_n = valid_q[i] | fill_we[i];
      if (flush)
        valid_n = 1'b0;
      else if (inv_valid && (tag_n == inv_vpn))
        valid_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
        pfn_q[i]   <= '0;
        wrok_q[i]  <= 1'b0;
        usrok_q[i] <= 1'b0;
      end else begin
        valid_q[i] <= valid_n;
        tag_q[i]   <= tag_n;
        if (fill_we[i]) begin
          pfn_q[i]   <= fill_pfn;
          wrok_q[i]  <= fill_wr_ok;
          usrok_q[i] <= fill_usr_ok;
        end
      end
    end

    assign hit_vec[i]        = valid_q[i] && (tag_q[i] == lk_vpn);
    assign fill_match_vec[i] = valid_q[i] && (tag_q[i] == fill_vpn);

    // R8
    inv_removes_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |=> !(valid_q[i] && (tag_q[i] == $past(inv_vpn))));
  end

  assign valid_vec = valid_q;

  always_comb begin
    hit_pfn    = '0;
    hit_wr_ok  = 1'b0;
    hit_usr_ok = 1'b0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (hit_vec[k]) begin
        hit_pfn    = hit_pfn | pfn_q[k];
        hit_wr_ok  = hit_wr_ok | wrok_q[k];
        hit_usr_ok = hit_usr_ok | usrok_q[k];
      end
    end
  end

  // R4
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

endmodule

// File: rtl/xlc_victim_sel.sv
module xlc_victim_sel #(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_go,
  input  logic               flush,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] fill_match_vec,
  output logic [ENTRIES-1:0] fill_we
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0]   rr_q;
  logic [ENTRIES-1:0] first_free;
  logic               any_free;
  logic               evict;

  always_comb begin
    first_free = '0;
    any_free   = 1'b0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (!valid_vec[k] && !any_free) begin
        first_free[k] = 1'b1;
        any_free      = 1'b1;
      end
    end
  end

  assign evict = fill_go && !(|fill_match_vec) && !any_free;

  always_comb begin
    fill_we = '0;
    if (fill_go) begin
      if (|fill_match_vec)
        fill_we = fill_match_vec;
      else if (any_free)
        fill_we = first_free;
      else
        fill_we[rr_q] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rr_q <= '0;
    else if (flush)
      rr_q <= '0;
    else if (evict)
      rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  // R11
  one_slot_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_we) && (fill_go -> (fill_we != '0)));

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PFN_W  = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  input  logic             lk_user,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [VA_W-1:0]  rsp_vaddr,
  output logic             rsp_write,
  output logic             rsp_user,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic             fill_err,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_wr_ok,
  input  logic             fill_usr_ok,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             base_wr
);

  logic [ENTRIES-1:0] valid_vec, hit_vec, fill_match_vec, fill_we;
  logic [PFN_W-1:0]   hit_pfn;
  logic               hit_wr_ok, hit_usr_ok;
  logic               fill_go;
  logic               lk_any_hit;
  rsp_kind_e          kind_n, kind_q;
  logic [PA_W-1:0]    paddr_n;

  assign fill_go = fill_valid && !fill_err;

  xlc_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(lk_vaddr[VA_W-1:OFF_W]),
    .fill_we(fill_we), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_wr_ok(fill_wr_ok), .fill_usr_ok(fill_usr_ok),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush(base_wr),
    .valid_vec(valid_vec), .hit_vec(hit_vec), .fill_match_vec(fill_match_vec),
    .hit_pfn(hit_pfn), .hit_wr_ok(hit_wr_ok), .hit_usr_ok(hit_usr_ok)
  );

  xlc_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .fill_go(fill_go), .flush(base_wr),
    .valid_vec(valid_vec), .fill_match_vec(fill_match_vec), .fill_we(fill_we)
  );

  assign lk_any_hit = |hit_vec;

  always_comb begin
    if (!lk_any_hit)
      kind_n = RK_MISS;
    else if (perm_denied(lk_write, lk_user, hit_wr_ok, hit_usr_ok))
      kind_n = RK_FAULT;
    else
      kind_n = RK_HIT;
    paddr_n = (kind_n == RK_HIT) ? {hit_pfn, lk_vaddr[OFF_W-1:0]} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      kind_q    <= RK_MISS;
      rsp_paddr <= '0;
      rsp_vaddr <= '0;
      rsp_write <= 1'b0;
      rsp_user  <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        kind_q    <= kind_n;
        rsp_paddr <= paddr_n;
        rsp_vaddr <= lk_vaddr;
        rsp_write <= lk_write;
        rsp_user  <= lk_user;
      end
    end
  end

  assign rsp_hit   = rsp_valid && (kind_q == RK_HIT);
  assign rsp_miss  = rsp_valid && (kind_q == RK_MISS);
  assign rsp_fault = rsp_valid && (kind_q == RK_FAULT);

  // R1
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  // R1
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  // R1
  resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

  // R5
  walk_err_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_err && !inv_valid && !base_wr) |=> $stable(valid_vec));

  // R3
  miss_paddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_miss || rsp_fault) |-> (rsp_paddr == '0));

endmodule

// File: tb/xlate_cache_bench.sv
module xlate_cache_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        lk_user = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_paddr, rsp_vaddr;
  logic        rsp_write, rsp_user;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic        fill_err = 1'b0;
  logic [19:0] fill_pfn = '0;
  logic        fill_wr_ok = 1'b0;
  logic        fill_usr_ok = 1'b0;
  logic        inv_valid = 1'b0;
  logic [19:0] inv_vpn = '0;
  logic        base_wr = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;   // 0 miss, 1 hit, 2 fault
    logic [31:0] paddr;
    logic [31:0] vaddr;
    logic        wr;
    logic        usr;
    string       req;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_cache u_xlate_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr), .rsp_write(rsp_write), .rsp_user(rsp_user),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_err(fill_err), .fill_pfn(fill_pfn),
    .fill_wr_ok(fill_wr_ok), .fill_usr_ok(fill_usr_ok),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .base_wr(base_wr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: one lookup, expected result pushed onto the scoreboard.
  task automatic lookup(input logic [31:0] va, input logic wr, input logic usr,
                        input int kind, input logic [19:0] pfn, input string req);
    exp_t e;
    e.kind  = kind;
    e.paddr = (kind == 1) ? {pfn, va[11:0]} : 32'h0;
    e.vaddr = va;
    e.wr    = wr;
    e.usr   = usr;
    e.req   = req;
    @(negedge clk);
    sb.push_back(e);
    lk_valid = 1'b1; lk_vaddr = va; lk_write = wr; lk_user = usr;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic wok, input logic uok, input logic err,
                        input logic with_inv, input logic with_flush);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
    fill_wr_ok = wok; fill_usr_ok = uok; fill_err = err;
    inv_valid = with_inv; inv_vpn = vpn; base_wr = with_flush;
    @(negedge clk);
    fill_valid = 1'b0; fill_err = 1'b0; inv_valid = 1'b0; base_wr = 1'b0;
  endtask

  task automatic invalidate(input logic [19:0] vpn);
    @(negedge clk);
    inv_valid = 1'b1; inv_vpn = vpn;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic flush_all();
    @(negedge clk);
    base_wr = 1'b1;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  // Monitor: compare each response against the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R1", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        int act_kind;
        e = sb.pop_front();
        act_kind = rsp_hit ? 1 : rsp_fault ? 2 : rsp_miss ? 0 : 3;
        check((rsp_hit + rsp_miss + rsp_fault) == 1, "R1", "result one-hot",
              {rsp_hit, rsp_miss, rsp_fault}, 0);
        check(act_kind == e.kind, e.req, "result kind", act_kind, e.kind);
        check(rsp_paddr == e.paddr, e.req, "paddr", rsp_paddr, e.paddr);
        check({rsp_vaddr, rsp_write, rsp_user} == {e.vaddr, e.wr, e.usr}, "R1",
              "echo", {rsp_vaddr, rsp_write, rsp_user}, {e.vaddr, e.wr, e.usr});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", "run did not finish", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check({rsp_valid, rsp_hit, rsp_miss, rsp_fault} == 4'b0, "R12", "outputs in reset",
          {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R12", "idle after reset", rsp_valid, 0);

    // R3: empty cache misses
    lookup(32'h0000_3012, 1'b0, 1'b0, 0, 20'h0, "R3");
    // R4, R2: refill then hit anywhere in the page
    refill(20'h00003, 20'h00ABC, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    lookup(32'h0000_39EC, 1'b0, 1'b1, 1, 20'h00ABC, "R2");
    lookup(32'h0000_3000, 1'b1, 1'b0, 1, 20'h00ABC, "R4");
    // R5: failed walk not stored
    refill(20'h00005, 20'h12345, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    lookup(32'h0000_5010, 1'b0, 1'b0, 0, 20'h0, "R5");
    // R6: read-only kernel page
    refill(20'h00007, 20'h11111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    lookup(32'h0000_7123, 1'b1, 1'b0, 2, 20'h0, "R6");
    lookup(32'h0000_7123, 1'b0, 1'b1, 2, 20'h0, "R6");
    lookup(32'h0000_7123, 1'b0, 1'b0, 1, 20'h11111, "R6");
    // R7: stale mapping still returned
    lookup(32'h0000_3ABC, 1'b0, 1'b0, 1, 20'h00ABC, "R7");
    // R4: refill of a cached page overwrites it
    refill(20'h00003, 20'h00DEF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    lookup(32'h0000_3ABC, 1'b0, 1'b0, 1, 20'h00DEF, "R4");
    // R8: invalidate one page only
    invalidate(20'h00003);
    lookup(32'h0000_3ABC, 1'b0, 1'b0, 0, 20'h0, "R8");
    lookup(32'h0000_7004, 1'b0, 1'b0, 1, 20'h11111, "R8");
    // R10: refill and invalidate of the same page together
    refill(20'h00009, 20'h22222, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    lookup(32'h0000_9000, 1'b0, 1'b0, 0, 20'h0, "R10");
    // R9: flush empties the cache
    flush_all();
    lookup(32'h0000_7004, 1'b0, 1'b0, 0, 20'h0, "R9");

    // R11: fill all eight slots, then evict round-robin
    for (int i = 0; i < 8; i++)
      refill(20'h00100 + 20'(i), 20'h50000 + 20'(i), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    refill(20'h00108, 20'h50008, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    lookup(32'h0010_0000, 1'b0, 1'b0, 0, 20'h0, "R11");
    lookup(32'h0010_1000, 1'b0, 1'b0, 1, 20'h50001, "R11");
    lookup(32'h0010_8000, 1'b0, 1'b0, 1, 20'h50008, "R11");
    refill(20'h00109, 20'h50009, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    lookup(32'h0010_1000, 1'b0, 1'b0, 0, 20'h0, "R11");
    lookup(32'h0010_2000, 1'b0, 1'b0, 1, 20'h50002, "R11");
    // open slot 5; next page goes there and the pointer stays on slot 2
    invalidate(20'h00105);
    refill(20'h0010A, 20'h5000A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    lookup(32'h0010_2000, 1'b0, 1'b0, 1, 20'h50002, "R11");
    lookup(32'h0010_A000, 1'b0, 1'b0, 1, 20'h5000A, "R11");
    refill(20'h0010B, 20'h5000B, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    lookup(32'h0010_2000, 1'b0, 1'b0, 0, 20'h0, "R11");
    lookup(32'h0010_3000, 1'b0, 1'b0, 1, 20'h50003, "R11");

    // R10: refill coinciding with a flush leaves nothing
    refill(20'h00200, 20'h60000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    lookup(32'h0020_0000, 1'b0, 1'b0, 0, 20'h0, "R10");
    lookup(32'h0010_3000, 1'b0, 1'b0, 0, 20'h0, "R10");
    // R9: pointer back at slot 0 after flush; fill 9 pages, ninth evicts first
    for (int i = 0; i < 9; i++)
      refill(20'h00300 + 20'(i), 20'h70000 + 20'(i), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    lookup(32'h0030_0000, 1'b0, 1'b0, 0, 20'h0, "R9");
    lookup(32'h0030_1000, 1'b0, 1'b0, 1, 20'h70001, "R9");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R1", "responses outstanding", sb.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule